// File: doc/BRIEF.md
# Dual-Map Paged Register Decoder

This block sits between a host bus and the register storage of a network controller. The host presents a 4-bit offset, a data byte and separate read and write strobes. The offset alone reaches only sixteen locations. A 2-bit page field, held in a command register, chooses which of four pages of sixteen those locations fall on. One bit of an enhancement register chooses between two complete address maps. The default map serves ring buffering and the alternate map serves linked-list buffering.

Several physical registers can be reached in both maps, though not always at the same page and offset. The decoder resolves each access to at most one physical register. It drives one-hot read and write enables and stores written bytes through per-register masks, so that void bits stay zero. It returns read data one cycle after the read strobe. Read responses come from a two-state machine. In `ST_IDLE`, a read strobe without a write strobe takes the transition `RD_ACCEPT` to `ST_RESP`. In `ST_RESP`, a further lone read strobe takes `RD_CHAIN` and stays in `ST_RESP`. Any other cycle in `ST_RESP` takes `RESP_DONE` back to `ST_IDLE`. Any other cycle in `ST_IDLE` takes `IDLE_HOLD` and stays there.

Top module: `paged_reg_decoder`

## Requirements
- R1: After reset the page is 0, the default map is selected, `bus_rvalid` and `bus_rdata` are 0, and the registers hold their reset values. Index 0 resets to 0x00, 1 to 0x00, 2 to 0x00, 3 to 0x05, 4 to 0xA5, 5 to 0x14, 6 to 0x40 and 7 to 0x30.
- R2: Register index 0 is the command register. Its bits [7:6] give the current page, shown on `cur_page`. It sits at offset 0x0 on every page in both maps.
- R3: Bit 7 of register index 1 selects the map: 0 for the default map, 1 for the alternate map. Its value is shown on `alt_map`.
- R4: The default map, listed as page:offset->index, is 0:1->2, 0:2->3, 0:3->4, 1:1->5, 2:4->6, 2:5->1 and 3:6->7. The alternate map is 0:1->2, 0:2->4, 1:3->3, 1:A->6, 3:9->1 and 0:F->7. Index 5 is absent from the alternate map.
- R5: A cycle with `bus_rd` high and `bus_wr` low produces `bus_rvalid`=1 in the next cycle, with the addressed register on `bus_rdata`. When `bus_rvalid` is 0, `bus_rdata` is 0. Back-to-back reads each get a response.
- R6: Writes store `wdata & mask`. The masks are 0xC7 for index 0, 0x9F for 1, 0xFF for 2, 0x0F for 3, 0xFF for 4, 0x3C for 5, 0x7F for 6 and 0xF0 for 7. Void bits always read 0.
- R7: A read of a location with no register still gives `bus_rvalid`=1, with `bus_rdata`=0. A write there changes no register.
- R8: `reg_rd_en` and `reg_wr_en` are combinational one-hot vectors, with bit i for register index i. Each is set only for a mapped access with its strobe, and is zero otherwise.
- R9: If both strobes are high in one cycle, only the write takes place. No read enable or read response is produced.
- R10: A page or map change written in one cycle decodes the access made in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_off | input | 4 | Register offset within the visible page |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| reg_rd_en | output | 8 | One-hot read enable per register |
| reg_wr_en | output | 8 | One-hot write enable per register |
| cur_page | output | 2 | Current page from the command register |
| alt_map | output | 1 | Alternate map selected |
| reg_q | output | 64 | All register contents, index i at bits [8i+7:8i] |

## Verification
The bench reaches the same register through both maps. A decoder that ignored the map bit would return the wrong register at alternate page 0 offset 2. It would also let the default-only register answer in the alternate map. Reads issued in the cycle right after a page or map write expose a decoder that registers its selection one cycle late. Writes of 0xFF show any void bit that gets stored. Offsets with no register, and cycles with both strobes high, catch a design that stores stray data or sends a read response nobody asked for.

// File: rtl/regdec_pkg.sv
package regdec_pkg;
    localparam int DATA_W   = 8;
    localparam int OFF_W    = 4;
    localparam int PAGE_W   = 2;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int PAGE_LSB = DATA_W - PAGE_W;
    localparam int MAP_BIT  = DATA_W - 1;
    localparam int IDX_CMD  = 0;
    localparam int IDX_ENH  = 1;

    typedef enum logic {ST_IDLE = 1'b0, ST_RESP = 1'b1} rsp_state_e;

    // storage mask: bits outside it are void and read as zero
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'hC7;
            1:       return 8'h9F;
            2:       return 8'hFF;
            3:       return 8'h0F;
            4:       return 8'hFF;
            5:       return 8'h3C;
            6:       return 8'h7F;
            7:       return 8'hF0;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        case (idx)
            3:       return 8'h05;
            4:       return 8'hA5;
            5:       return 8'h14;
            6:       return 8'h40;
            7:       return 8'h30;
            default: return '0;
        endcase
    endfunction

    // returns {hit, index}
    function automatic logic [IDX_W:0] map_lookup(input logic alt,
                                                  input logic [PAGE_W-1:0] pg,
                                                  input logic [OFF_W-1:0] off);
        logic [IDX_W:0] r;
        r = '0;
        if (off == '0) begin
            r = {1'b1, IDX_W'(IDX_CMD)};
        end else if (!alt) begin
            case ({pg, off})
                6'h01:   r = {1'b1, IDX_W'(2)};
                6'h02:   r = {1'b1, IDX_W'(3)};
                6'h03:   r = {1'b1, IDX_W'(4)};
                6'h11:   r = {1'b1, IDX_W'(5)};
                6'h24:   r = {1'b1, IDX_W'(6)};
                6'h25:   r = {1'b1, IDX_W'(IDX_ENH)};
                6'h36:   r = {1'b1, IDX_W'(7)};
                default: r = '0;
            endcase
        end else begin
            case ({pg, off})
                6'h01:   r = {1'b1, IDX_W'(2)};
                6'h02:   r = {1'b1, IDX_W'(4)};
                6'h13:   r = {1'b1, IDX_W'(3)};
                6'h1A:   r = {1'b1, IDX_W'(6)};
                6'h39:   r = {1'b1, IDX_W'(IDX_ENH)};
                6'h0F:   r = {1'b1, IDX_W'(7)};
                default: r = '0;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/regdec_map_decode.sv
module regdec_map_decode
    import regdec_pkg::*;
(
    input  logic                alt,
    input  logic [PAGE_W-1:0]   page,
    input  logic [OFF_W-1:0]    off,
    output logic                hit,
    output logic [NUM_REGS-1:0] sel
);
    logic [IDX_W:0]   look;
    logic [IDX_W-1:0] idx;

    always_comb begin
        look = map_lookup(alt, page, off);
        hit  = look[IDX_W];
        idx  = look[IDX_W-1:0];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i] = hit && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/regdec_bank.sv
module regdec_bank
    import regdec_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_REGS-1:0]          wr_sel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_REGS*DATA_W-1:0]   q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = reg_mask(i);
        localparam logic [DATA_W-1:0] RST  = reg_reset(i);
        logic [DATA_W-1:0] val;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val <= RST;
            else if (wr_sel[i])
                val <= wdata & MASK;
        end

        assign q[i*DATA_W +: DATA_W] = val;
    end
endmodule

// File: rtl/regdec_rsp_fsm.sv
module regdec_rsp_fsm
    import regdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    rsp_state_e        state, state_nxt;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = rd_go ? ST_RESP : ST_IDLE; // RD_ACCEPT / IDLE_HOLD
            ST_RESP: state_nxt = rd_go ? ST_RESP : ST_IDLE; // RD_CHAIN / RESP_DONE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            state  <= state_nxt;
            data_q <= rd_go ? rd_word : '0;
        end
    end

    always_comb begin
        rvalid = (state == ST_RESP);
        rdata  = rvalid ? data_q : '0;
    end
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
    import regdec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OFF_W-1:0]           bus_off,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid,
    output logic [NUM_REGS-1:0]        reg_rd_en,
    output logic [NUM_REGS-1:0]        reg_wr_en,
    output logic [PAGE_W-1:0]          cur_page,
    output logic                       alt_map,
    output logic [NUM_REGS*DATA_W-1:0] reg_q
);
    logic                hit;
    logic [NUM_REGS-1:0] sel;
    logic                rd_go;
    logic [DATA_W-1:0]   rd_word;

    assign cur_page = reg_q[IDX_CMD*DATA_W + PAGE_LSB +: PAGE_W];
    assign alt_map  = reg_q[IDX_ENH*DATA_W + MAP_BIT];

    regdec_map_decode u_dec (
        .alt  (alt_map),
        .page (cur_page),
        .off  (bus_off),
        .hit  (hit),
        .sel  (sel)
    );

    // write takes precedence over a simultaneous read
    assign rd_go     = bus_rd && !bus_wr;
    assign reg_wr_en = bus_wr ? sel : '0;
    assign reg_rd_en = rd_go  ? sel : '0;

    regdec_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (reg_wr_en),
        .wdata  (bus_wdata),
        .q      (reg_q)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (sel[i]) rd_word = rd_word | reg_q[i*DATA_W +: DATA_W];
    end

    regdec_rsp_fsm u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (rd_go),
        .rd_word (rd_word),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/regdec_checker.sv
module regdec_checker
    import regdec_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_rd,
    input logic                       bus_wr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       bus_rvalid,
    input logic [NUM_REGS-1:0]        reg_rd_en,
    input logic [NUM_REGS-1:0]        reg_wr_en,
    input logic [PAGE_W-1:0]          cur_page,
    input logic [NUM_REGS*DATA_W-1:0] reg_q
);
    p_rd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rd_en));
    p_wr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wr_en));
    p_resp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);
    p_no_stray_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> !bus_rvalid);
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (reg_rd_en == '0));
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en[IDX_CMD] |=> $stable(cur_page));
    p_unmapped_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_wr_en == '0) |=> $stable(reg_q));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_void
        p_void_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_q[i*DATA_W +: DATA_W] & ~reg_mask(i)) == '0);
    end
endmodule

bind paged_reg_decoder regdec_checker u_chk (.*);

// File: tb/sim_paged_reg_decoder.sv
`timescale 1ns/1ps
module sim_paged_reg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_off = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  reg_rd_en;
    logic [7:0]  reg_wr_en;
    logic [1:0]  cur_page;
    logic        alt_map;
    logic [63:0] reg_q;

    always #4 clk = ~clk;

    paged_reg_decoder u0 (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    int mq[8];
    int msk[8] = '{8'hC7, 8'h9F, 8'hFF, 8'h0F, 8'hFF, 8'h3C, 8'h7F, 8'hF0};
    int rstv[8] = '{8'h00, 8'h00, 8'h00, 8'h05, 8'hA5, 8'h14, 8'h40, 8'h30};
    int ring_map[int];
    int link_map[int];
    int exp_rv = 0;
    int exp_rd = 0;

    function automatic int where(int off);
        int key;
        int pg;
        int alt;
        pg  = (mq[0] >> 6) & 3;
        alt = (mq[1] >> 7) & 1;
        key = pg * 16 + off;
        if (off == 0) return 0;
        if (alt == 0 && ring_map.exists(key)) return ring_map[key];
        if (alt == 1 && link_map.exists(key)) return link_map[key];
        return -1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_state(string tag);
        chk(tag, "rvalid (R5)", int'(bus_rvalid), exp_rv);
        chk(tag, "rdata (R5/R7)", int'(bus_rdata), exp_rd);
        chk(tag, "page (R2)", int'(cur_page), (mq[0] >> 6) & 3);
        chk(tag, "alt map (R3)", int'(alt_map), (mq[1] >> 7) & 1);
        for (int i = 0; i < 8; i++)
            chk(tag, $sformatf("reg %0d (R6)", i), int'(reg_q[i*8 +: 8]), mq[i]);
    endtask

    // one bus cycle; entered and left at a falling edge
    task automatic cyc(string tag, int off, int wd, bit rd, bit wr);
        int idx;
        int e_rden;
        int e_wren;
        bus_off = 4'(off); bus_wdata = 8'(wd); bus_rd = rd; bus_wr = wr;
        #1;
        idx = where(off);
        e_rden = (rd && !wr && idx >= 0) ? (1 << idx) : 0;
        e_wren = (wr && idx >= 0) ? (1 << idx) : 0;
        chk(tag, "rd_en (R8)", int'(reg_rd_en), e_rden);
        chk(tag, "wr_en (R8)", int'(reg_wr_en), e_wren);
        @(posedge clk);
        exp_rv = (rd && !wr) ? 1 : 0;
        exp_rd = (exp_rv == 1 && idx >= 0) ? mq[idx] : 0;
        if (wr && idx >= 0) mq[idx] = wd & msk[idx];
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        check_state(tag);
    endtask

    task automatic rd(string tag, int off);
        cyc(tag, off, 0, 1'b1, 1'b0);
    endtask

    task automatic wr(string tag, int off, int wd);
        cyc(tag, off, wd, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        ring_map[8'h01] = 2; ring_map[8'h02] = 3; ring_map[8'h03] = 4;
        ring_map[8'h11] = 5; ring_map[8'h24] = 6; ring_map[8'h25] = 1;
        ring_map[8'h36] = 7;
        link_map[8'h01] = 2; link_map[8'h02] = 4; link_map[8'h13] = 3;
        link_map[8'h1A] = 6; link_map[8'h39] = 1; link_map[8'h0F] = 7;
        for (int i = 0; i < 8; i++) mq[i] = rstv[i];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 reset");

        // default map reads on page 0
        rd("R4 ring p0", 4'h1);
        rd("R4 ring p0", 4'h2);
        rd("R5 back-to-back", 4'h3);
        rd("R2 cmd p0", 4'h0);
        // void bits: all ones written
        wr("R6 mask", 4'h2, 8'hFF);
        rd("R6 readback", 4'h2);
        // unmapped offsets
        wr("R7 unmapped wr", 4'hC, 8'h5A);
        rd("R7 unmapped rd", 4'hC);
        // page 1, then an immediate read
        wr("R10 page", 4'h0, 8'h40);
        rd("R10 next read", 4'h1);
        wr("R6 mask", 4'h1, 8'hFF);
        // page 2 holds the map-select register in the default map
        wr("R2 page", 4'h0, 8'h80);
        rd("R4 ring p2", 4'h4);
        wr("R3 go alt", 4'h5, 8'hFF);
        rd("R10 alt next", 4'h5);    // unmapped in the alternate map
        // alternate map
        wr("R2 page", 4'h0, 8'h00);
        rd("R4 alt idx4", 4'h2);
        rd("R4 alt idx7", 4'hF);
        wr("R2 page", 4'h0, 8'h40);
        rd("R3 idx5 absent", 4'h1);
        rd("R4 alt idx3", 4'h3);
        rd("R4 alt idx6", 4'hA);
        // both strobes
        cyc("R9 both", 4'hA, 8'h12, 1'b1, 1'b1);
        rd("R9 readback", 4'hA);
        // back to the default map via the alternate location
        wr("R2 page", 4'h0, 8'hC0);
        wr("R3 go ring", 4'h9, 8'h00);
        rd("R10 ring next", 4'h6);

        // random traffic against the model
        for (int k = 0; k < 2000; k++) begin
            int o;
            int d;
            bit r;
            bit w;
            o = $urandom_range(0, 15);
            d = $urandom_range(0, 255);
            r = 1'($urandom_range(0, 1));
            w = 1'($urandom_range(0, 3) == 0);
            if (o == 0 && w) d = $urandom_range(0, 255);
            cyc("R4 random", o, d, r, w);
        end

        done = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule